// File: doc/BRIEF.md
# Indexed Configuration Port with Password Lock

This block is the configuration front end of a multi-function I/O controller. It answers at two byte-wide host I/O addresses. The index port (0x2E) latches a register number. The data port (0x2F) reads or writes the register that number names. A host reaches a register by writing its number to the index port and then reading or writing the data port.

The whole register space starts out locked. It opens only after the host writes the value 0xA5 to the index port twice in a row. Writing 0xAA to the index port closes it again and drops the chosen logical device. Two registers live inside the block itself:

- Register 0x07 picks a logical device by number. The legal numbers are 2, 3, 4, 5, 7, 0x0B, 0x0C, 0x0D and 0x0E.
- Register 0x30 holds that device's enable bit.

Every other register number is passed to the device register files over a narrow internal bus. That bus carries the device number, register number, write data and a write strobe or read strobe, and it returns read data in the same cycle.

Top module: `sio_cfg_port`

## Requirements
- R1: Only the exact addresses INDEX_ADDR (0x2E) and DATA_ADDR (0x2F) are decoded. An access to any other address leaves the lock state, index, selection and enables unchanged and reads back 0xFF.
- R2: Two consecutive index-port writes of 0xA5 while locked unlock the space. The write that completes the pair takes effect at the clock edge that ends it.
- R3: While locked, an index-port write of any value other than 0xA5 restarts the unlock sequence, so a further two 0xA5 writes are needed.
- R4: While unlocked, an index-port write of 0xAA relocks the space, clears the device selection and resets the index to 0x00. Enable bits are kept.
- R5: A data-port write with index 0x07 selects the device whose number is written, if that number is in the legal set. An illegal number leaves the previous selection in place. A data-port read with index 0x07 returns the selected number, or 0x00 when no device is selected.
- R6: With a device selected, a data-port write with index 0x30 sets that device's enable bit to bit 0 of the data. Output `dev_enable` bit n shows device n's enable. A read of 0x30 returns 0x00 or 0x01. Accesses to 0x30 and 0x07 never raise the internal bus strobes.
- R7: With a device selected, a data-port access to any other register raises `dev_wr` or `dev_rd` in that same cycle. The bus carries the device number, the index and the write data, and a read returns `dev_rdata` on `io_rdata`.
- R8: While locked, data-port writes are ignored, data-port reads return 0xFF and no internal bus strobe is raised.
- R9: Reset (synchronous, active high) leaves the block locked, with no device selected, all enables clear and the index at 0x00.
- R10: An index-port read returns the latched index while unlocked and 0xFF while locked.
- R11: While unlocked with no device selected, data-port accesses to registers other than 0x07 raise no strobe, and their reads return 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | ADDR_W | Host I/O address |
| io_wdata | input | 8 | Host write data |
| io_wr | input | 1 | Host write strobe, one cycle per access |
| io_rd | input | 1 | Host read strobe, one cycle per access |
| io_rdata | output | 8 | Host read data, valid in the strobe cycle |
| dev_num | output | 8 | Selected logical device number on the internal bus |
| dev_reg | output | 8 | Register number on the internal bus |
| dev_wdata | output | 8 | Write data on the internal bus |
| dev_wr | output | 1 | Internal bus write strobe |
| dev_rd | output | 1 | Internal bus read strobe |
| dev_rdata | input | 8 | Read data returned by the selected device, same cycle |
| dev_enable | output | DEV_SPACE | Enable bit per device number |

## Verification
The unlock logic is driven with three patterns: a clean 0xA5 pair, a pair broken by another index value, and 0xA5 pairs sent to an address that matches only in its low byte. Together these separate a counter that restarts from one that merely pauses, and a full address compare from a partial one. Device accesses are made to two different devices and to several register numbers. The read data is a function of both device and register, so a wrong device number or a stale index shows up as a wrong byte. Writes of an illegal device number, accesses with no device selected, and accesses to 0x07 and 0x30 show whether the gating keeps local registers off the internal bus and keeps unselected accesses off it entirely.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;

    typedef logic [7:0] byte_t;

    localparam byte_t KEY_OPEN    = 8'hA5;
    localparam byte_t KEY_CLOSE   = 8'hAA;
    localparam byte_t REG_DEVSEL  = 8'h07;
    localparam byte_t REG_ENABLE  = 8'h30;
    localparam byte_t READ_IDLE   = 8'hFF;
    localparam byte_t NO_DEVICE   = 8'h00;

    // Lock sequencer states: HALF means one 0xA5 has been seen.
    typedef enum logic [1:0] {
        LK_LOCKED = 2'd0,
        LK_HALF   = 2'd1,
        LK_OPEN   = 2'd2
    } lock_state_e;

    // Decoded host access.
    typedef struct packed {
        logic  wr;
        logic  rd;
        logic  at_index;
        logic  at_data;
        byte_t wdata;
    } io_req_t;

    function automatic logic is_valid_dev(input byte_t num);
        case (num)
            8'h02, 8'h03, 8'h04, 8'h05, 8'h07,
            8'h0B, 8'h0C, 8'h0D, 8'h0E: return 1'b1;
            default:                    return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/sio_addr_decode.sv
module sio_addr_decode
    import sio_cfg_pkg::*;
#(
    parameter int              ADDR_W     = 16,
    parameter logic [ADDR_W-1:0] INDEX_ADDR = 'h2E,
    parameter logic [ADDR_W-1:0] DATA_ADDR  = 'h2F
) (
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [7:0]        io_wdata,
    input  logic              io_wr,
    input  logic              io_rd,
    output io_req_t           req
);

    always_comb begin
        req.wr       = io_wr;
        req.rd       = io_rd;
        req.at_index = (io_addr == INDEX_ADDR);
        req.at_data  = (io_addr == DATA_ADDR);
        req.wdata    = io_wdata;
    end

endmodule

// File: rtl/sio_lock_fsm.sv
module sio_lock_fsm
    import sio_cfg_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  idx_wr,
    input  byte_t wdata,
    output logic  unlocked,
    output logic  relock
);

    lock_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (idx_wr) begin
            unique case (state_q)
                LK_LOCKED: state_d = (wdata == KEY_OPEN) ? LK_HALF : LK_LOCKED;
                LK_HALF:   state_d = (wdata == KEY_OPEN) ? LK_OPEN : LK_LOCKED;
                LK_OPEN:   state_d = (wdata == KEY_CLOSE) ? LK_LOCKED : LK_OPEN;
                default:   state_d = LK_LOCKED;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= LK_LOCKED;
        else     state_q <= state_d;
    end

    assign unlocked = (state_q == LK_OPEN);
    assign relock   = unlocked && idx_wr && (wdata == KEY_CLOSE);

    AST_OPEN_AFTER_KEY: assert property (@(posedge clk) disable iff (rst)
        $rose(unlocked) |-> $past(idx_wr && wdata == KEY_OPEN)); // R2

    AST_CLOSE_ON_KEY: assert property (@(posedge clk) disable iff (rst)
        (unlocked && idx_wr && wdata == KEY_CLOSE) |=> !unlocked); // R4

    AST_STAY_LOCKED: assert property (@(posedge clk) disable iff (rst)
        (!unlocked && !idx_wr) |=> !unlocked); // R1

endmodule

// File: rtl/sio_cfg_regs.sv
module sio_cfg_regs
    import sio_cfg_pkg::*;
#(
    parameter int DEV_SPACE = 16,
    localparam int DEV_W    = $clog2(DEV_SPACE)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 unlocked,
    input  logic                 relock,
    input  logic                 idx_wr,
    input  logic                 dat_wr,
    input  byte_t                wdata,
    output byte_t                index,
    output logic                 sel_valid,
    output logic [DEV_W-1:0]     sel_dev,
    output logic [DEV_SPACE-1:0] enables
);

    logic open_idx_wr, open_dat_wr;

    assign open_idx_wr = unlocked && idx_wr && !relock;
    assign open_dat_wr = unlocked && dat_wr;

    always_ff @(posedge clk) begin
        if (rst || relock)   index <= 8'h00;
        else if (open_idx_wr) index <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst || relock) begin
            sel_valid <= 1'b0;
            sel_dev   <= '0;
        end else if (open_dat_wr && index == REG_DEVSEL && is_valid_dev(wdata)) begin
            sel_valid <= 1'b1;
            sel_dev   <= wdata[DEV_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            enables <= '0;
        end else if (open_dat_wr && sel_valid && index == REG_ENABLE) begin
            enables[sel_dev] <= wdata[0];
        end
    end

    AST_SEL_LEGAL: assert property (@(posedge clk) disable iff (rst)
        sel_valid |-> is_valid_dev(byte_t'(sel_dev))); // R5

    AST_SEL_NEEDS_OPEN: assert property (@(posedge clk) disable iff (rst)
        !unlocked |-> !sel_valid); // R4

    generate
        for (genvar g = 0; g < DEV_SPACE; g++) begin : g_en_chk
            if (!is_valid_dev(byte_t'(g))) begin : g_unused
                AST_EN_UNUSED: assert property (@(posedge clk) disable iff (rst)
                    !enables[g]); // R6
            end
        end
    endgenerate

endmodule

// File: rtl/sio_access_mux.sv
module sio_access_mux
    import sio_cfg_pkg::*;
#(
    parameter int DEV_SPACE = 16,
    localparam int DEV_W    = $clog2(DEV_SPACE)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  io_req_t              req,
    input  logic                 unlocked,
    input  byte_t                index,
    input  logic                 sel_valid,
    input  logic [DEV_W-1:0]     sel_dev,
    input  logic [DEV_SPACE-1:0] enables,
    input  byte_t                dev_rdata,
    output byte_t                io_rdata,
    output byte_t                dev_num,
    output byte_t                dev_reg,
    output byte_t                dev_wdata,
    output logic                 dev_wr,
    output logic                 dev_rd
);

    logic local_reg, forward_ok;

    assign local_reg  = (index == REG_DEVSEL) || (index == REG_ENABLE);
    assign forward_ok = unlocked && sel_valid && !local_reg && req.at_data;

    assign dev_wr    = req.wr && forward_ok;
    assign dev_rd    = req.rd && forward_ok;
    assign dev_num   = byte_t'(sel_dev);
    assign dev_reg   = index;
    assign dev_wdata = req.wdata;

    always_comb begin
        io_rdata = READ_IDLE;
        if (unlocked) begin
            if (req.at_index) begin
                io_rdata = index;
            end else if (req.at_data) begin
                if (index == REG_DEVSEL)
                    io_rdata = sel_valid ? byte_t'(sel_dev) : NO_DEVICE;
                else if (index == REG_ENABLE)
                    io_rdata = sel_valid ? {7'b0, enables[sel_dev]} : READ_IDLE;
                else if (sel_valid)
                    io_rdata = dev_rdata;
            end
        end
    end

    AST_NO_FWD_LOCKED: assert property (@(posedge clk) disable iff (rst)
        !unlocked |-> (!dev_wr && !dev_rd)); // R8

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({dev_wr, dev_rd})); // R7

    AST_FWD_NEEDS_SEL: assert property (@(posedge clk) disable iff (rst)
        (dev_wr || dev_rd) |-> sel_valid); // R11

endmodule

// File: rtl/sio_cfg_port.sv
module sio_cfg_port
    import sio_cfg_pkg::*;
#(
    parameter int                ADDR_W     = 16,
    parameter logic [ADDR_W-1:0] INDEX_ADDR = 'h2E,
    parameter logic [ADDR_W-1:0] DATA_ADDR  = 'h2F,
    parameter int                DEV_SPACE  = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [ADDR_W-1:0]    io_addr,
    input  logic [7:0]           io_wdata,
    input  logic                 io_wr,
    input  logic                 io_rd,
    output logic [7:0]           io_rdata,
    output logic [7:0]           dev_num,
    output logic [7:0]           dev_reg,
    output logic [7:0]           dev_wdata,
    output logic                 dev_wr,
    output logic                 dev_rd,
    input  logic [7:0]           dev_rdata,
    output logic [DEV_SPACE-1:0] dev_enable
);

    localparam int DEV_W = $clog2(DEV_SPACE);

    io_req_t          req;
    logic             unlocked, relock, sel_valid;
    byte_t            index;
    logic [DEV_W-1:0] sel_dev;

    sio_addr_decode #(
        .ADDR_W(ADDR_W), .INDEX_ADDR(INDEX_ADDR), .DATA_ADDR(DATA_ADDR)
    ) i_decode (
        .io_addr(io_addr), .io_wdata(io_wdata), .io_wr(io_wr), .io_rd(io_rd),
        .req(req)
    );

    sio_lock_fsm i_lock (
        .clk(clk), .rst(rst),
        .idx_wr(req.wr && req.at_index), .wdata(req.wdata),
        .unlocked(unlocked), .relock(relock)
    );

    sio_cfg_regs #(.DEV_SPACE(DEV_SPACE)) i_regs (
        .clk(clk), .rst(rst), .unlocked(unlocked), .relock(relock),
        .idx_wr(req.wr && req.at_index), .dat_wr(req.wr && req.at_data),
        .wdata(req.wdata), .index(index), .sel_valid(sel_valid),
        .sel_dev(sel_dev), .enables(dev_enable)
    );

    sio_access_mux #(.DEV_SPACE(DEV_SPACE)) i_mux (
        .clk(clk), .rst(rst), .req(req), .unlocked(unlocked), .index(index),
        .sel_valid(sel_valid), .sel_dev(sel_dev), .enables(dev_enable),
        .dev_rdata(dev_rdata), .io_rdata(io_rdata), .dev_num(dev_num),
        .dev_reg(dev_reg), .dev_wdata(dev_wdata), .dev_wr(dev_wr), .dev_rd(dev_rd)
    );

endmodule

// File: tb/test_sio_cfg_port.sv
`timescale 1ns/1ps
module test_sio_cfg_port;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] io_addr = '0;
    logic [7:0]  io_wdata = '0;
    logic        io_wr = 1'b0, io_rd = 1'b0;
    logic [7:0]  io_rdata, dev_num, dev_reg, dev_wdata, dev_rdata;
    logic        dev_wr, dev_rd;
    logic [15:0] dev_enable;

    int applied = 0, miscompares = 0;
    logic       saw_wr, saw_rd;
    logic [7:0] saw_num, saw_reg, saw_dat, rv;

    always #2.5 clk = ~clk;

    // Device model: read data depends on both device number and register.
    assign dev_rdata = {dev_num[3:0], dev_reg[3:0]} ^ 8'h5A;

    sio_cfg_port i_sio_cfg_port (
        .clk(clk), .rst(rst), .io_addr(io_addr), .io_wdata(io_wdata),
        .io_wr(io_wr), .io_rd(io_rd), .io_rdata(io_rdata), .dev_num(dev_num),
        .dev_reg(dev_reg), .dev_wdata(dev_wdata), .dev_wr(dev_wr), .dev_rd(dev_rd),
        .dev_rdata(dev_rdata), .dev_enable(dev_enable)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        applied++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic io_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        #1;
        saw_wr = dev_wr; saw_rd = dev_rd;
        saw_num = dev_num; saw_reg = dev_reg; saw_dat = dev_wdata;
        @(posedge clk);
        #1 io_wr = 1'b0;
    endtask

    task automatic io_read(input logic [15:0] a, output logic [7:0] v);
        @(negedge clk);
        io_addr = a; io_rd = 1'b1;
        #1;
        v = io_rdata; saw_rd = dev_rd; saw_wr = dev_wr;
        @(posedge clk);
        #1 io_rd = 1'b0;
    endtask

    // {kind (0 write, 1 read-check), req number, addr, data, expected}
    localparam int NV = 25;
    localparam logic [28:0] VEC [NV] = '{
        {1'b0, 4'd2,  8'h2E, 8'hA5, 8'h00},  // R2 first key
        {1'b0, 4'd2,  8'h2E, 8'hA5, 8'h00},  // R2 second key
        {1'b1, 4'd11, 8'h2F, 8'h00, 8'hFF},  // R11 no device yet
        {1'b0, 4'd5,  8'h2E, 8'h07, 8'h00},
        {1'b0, 4'd5,  8'h2F, 8'h02, 8'h00},
        {1'b1, 4'd5,  8'h2F, 8'h00, 8'h02},  // R5 select 2
        {1'b0, 4'd7,  8'h2E, 8'h41, 8'h00},
        {1'b1, 4'd7,  8'h2F, 8'h00, 8'h7B},  // R7 dev 2 reg 41
        {1'b1, 4'd10, 8'h2E, 8'h00, 8'h41},  // R10 index readback
        {1'b0, 4'd5,  8'h2E, 8'h07, 8'h00},
        {1'b0, 4'd5,  8'h2F, 8'h0E, 8'h00},
        {1'b1, 4'd5,  8'h2F, 8'h00, 8'h0E},  // R5 select 0E
        {1'b0, 4'd7,  8'h2E, 8'h12, 8'h00},
        {1'b1, 4'd7,  8'h2F, 8'h00, 8'hB8},  // R7 dev E reg 12
        {1'b0, 4'd5,  8'h2E, 8'h07, 8'h00},
        {1'b0, 4'd5,  8'h2F, 8'h06, 8'h00},  // illegal number
        {1'b1, 4'd5,  8'h2F, 8'h00, 8'h0E},  // R5 selection kept
        {1'b0, 4'd5,  8'h2F, 8'h0D, 8'h00},
        {1'b1, 4'd5,  8'h2F, 8'h00, 8'h0D},  // R5 select 0D
        {1'b0, 4'd6,  8'h2E, 8'h30, 8'h00},
        {1'b0, 4'd6,  8'h2F, 8'h01, 8'h00},
        {1'b1, 4'd6,  8'h2F, 8'h00, 8'h01},  // R6 enable readback
        {1'b0, 4'd4,  8'h2E, 8'hAA, 8'h00},  // R4 relock
        {1'b1, 4'd8,  8'h2F, 8'h00, 8'hFF},  // R8 locked data read
        {1'b1, 4'd10, 8'h2E, 8'h00, 8'hFF}   // R10 locked index read
    };

    initial begin
        #(200000 * 5);
        miscompares++;
        $display("FAIL watchdog expired (all requirements) actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R9 reset state
        chk(32'(dev_enable), 32'h0, "R9 enables after reset");
        io_read(16'h2E, rv); chk(32'(rv), 32'hFF, "R9 locked index read");
        io_read(16'h2F, rv); chk(32'(rv), 32'hFF, "R9 locked data read");

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][28]) begin
                io_read({8'h00, VEC[i][23:16]}, rv);
                chk(32'(rv), 32'(VEC[i][7:0]),
                    $sformatf("R%0d vector %0d", VEC[i][27:24], i));
            end else begin
                io_write({8'h00, VEC[i][23:16]}, VEC[i][15:8]);
            end
        end

        // R6 enable kept across relock, bit 13 for device 0x0D
        chk(32'(dev_enable), 32'h2000, "R6 enable bit for 0D");

        // R8 locked data write raises no strobe
        io_write(16'h2F, 8'h55); chk(32'(saw_wr), 32'h0, "R8 no strobe when locked");

        // R1 keys at an address matching only in the low byte
        io_write(16'h012E, 8'hA5);
        io_write(16'h012E, 8'hA5);
        io_read(16'h2E, rv); chk(32'(rv), 32'hFF, "R1 other address ignored");
        io_read(16'h012F, rv); chk(32'(rv), 32'hFF, "R1 other address reads FF");

        // R3 interrupted sequence
        io_write(16'h2E, 8'hA5);
        io_write(16'h2E, 8'h00);
        io_write(16'h2E, 8'hA5);
        io_read(16'h2E, rv); chk(32'(rv), 32'hFF, "R3 broken pair stays locked");
        io_write(16'h2E, 8'hA5);
        io_read(16'h2E, rv); chk(32'(rv), 32'h00, "R2 unlock after pair, index reset");

        // R4 selection cleared by relock
        io_write(16'h2E, 8'h07);
        io_read(16'h2F, rv); chk(32'(rv), 32'h00, "R4 no device after relock");

        // R11 no device selected
        io_write(16'h2E, 8'h41);
        io_write(16'h2F, 8'h33); chk(32'(saw_wr), 32'h0, "R11 no write strobe");
        io_read(16'h2F, rv);
        chk(32'(rv), 32'hFF, "R11 read FF");
        chk(32'(saw_rd), 32'h0, "R11 no read strobe");

        // R7 forwarding to device 3
        io_write(16'h2E, 8'h07);
        io_write(16'h2F, 8'h03);
        io_write(16'h2E, 8'h55);
        io_write(16'h2F, 8'hC6);
        chk(32'(saw_wr), 32'h1, "R7 write strobe");
        chk(32'({saw_num, saw_reg, saw_dat}), 32'h0355C6, "R7 bus fields");
        io_read(16'h2F, rv);
        chk(32'(rv), 32'h6F, "R7 read data");
        chk(32'(saw_rd), 32'h1, "R7 read strobe");

        // R6 enable register is local
        io_write(16'h2E, 8'h30);
        io_write(16'h2F, 8'h01); chk(32'(saw_wr), 32'h0, "R6 enable write not forwarded");
        chk(32'(dev_enable), 32'h2008, "R6 enable device 3");
        io_write(16'h2F, 8'h00);
        chk(32'(dev_enable), 32'h2000, "R6 disable device 3");

        // R9 reset mid-run
        @(negedge clk); rst = 1'b1;
        repeat (2) @(posedge clk);
        #1 rst = 1'b0;
        chk(32'(dev_enable), 32'h0, "R9 enables cleared");
        io_read(16'h2E, rv); chk(32'(rv), 32'hFF, "R9 locked again");

        $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
        $finish;
    end

endmodule